// File: doc/BRIEF.md
# Masked-Match Memory Bank Decoder

This block maps a physical address onto one of four memory banks of a memory controller. Each bank holds a decode word made of a valid flag and two key/mask pairs. One pair covers an upper slice of the address and the other a lower slice. A mask bit of one marks the matching address bit as don't-care. When a lookup strobe comes with an address, every bank is tested at once. One clock later the block reports whether any bank claimed the address, the lowest-numbered bank that did, and a global bank number built from the controller's port number.

The same decode words also describe each bank's geometry. The block derives each bank's base address, interleave factor and size from those fields and drives them continuously on read-only outputs. Decode words are loaded through a one-cycle write port that carries a bank index and a packed word.

Top module: `mem_bank_decoder`

## Requirements
- R1: A bank whose valid flag is clear never matches, whatever its other fields hold.
- R2: The upper field is address bits [42:26]. It matches when each bit that differs from the 12-bit upper key, zero-extended to 17 bits, has its bit set in the 12-bit upper mask, also zero-extended.
- R3: The lower field is address bits [9:6]. It is checked the same way against the 4-bit lower key and mask, and a bank hits only when both fields match.
- R4: When several banks match, the lowest bank index is reported.
- R5: The global bank number equals 4 × port_id + bank index, taken from the port_id present with the lookup strobe.
- R6: hit, hit_bank and hit_gid change on the clock edge after a cycle with lookup_valid high. After any other cycle, and on a miss, hit is 0, hit_bank is 0 and hit_gid is 0.
- R7: The interleave factor comes from the lower mask: 0xF gives 1, 0xE gives 2, 0xC gives 4, 0x8 gives 8, 0x0 gives 16, and any other value gives 1.
- R8: The base address is (upper key AND NOT upper mask) shifted left by 26.
- R9: The bank size is ((upper mask bits [9:0]) + 1) × 2^26 divided by the interleave factor. Upper mask bits 10 and 11 have no effect on size.
- R10: Each write word holds the lower key in [3:0], the lower mask in [7:4], the upper key in [19:8], the upper mask in [31:20] and the valid flag in [32]. A write with cfg_we high loads bank cfg_bank at the clock edge. Reset clears every field of every bank, which gives base 0, interleave 16 and size 2^22.
- R11: An address with any of bits [42:38] set never matches, because the stored key and mask have no bits there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Decode word write enable |
| cfg_bank | input | 2 | Bank written |
| cfg_data | input | 33 | Packed decode word |
| port_id | input | 5 | Controller port number |
| lookup_valid | input | 1 | Lookup strobe |
| lookup_addr | input | 43 | Physical address to decode |
| hit | output | 1 | Some bank matched (registered) |
| hit_bank | output | 2 | Lowest matching bank |
| hit_gid | output | 7 | Global bank number |
| bank_base | output | 172 | Per-bank base address, bank b at [b*43 +: 43] |
| bank_ilv | output | 20 | Per-bank interleave factor, bank b at [b*5 +: 5] |
| bank_size | output | 172 | Per-bank size in bytes, bank b at [b*43 +: 43] |

## Verification
The bench builds the block with its default parameters: four banks, a 43-bit address, a 17-bit upper field holding a 12-bit key and mask, and a 4-bit lower field. These sizes expose the unstored top five upper-field bits, so the miss on bits [42:38] is reachable. With all four banks in use, two banks can match the same address, which tests the priority order. The global bank number is tested at a non-zero port number. The interleave decode is swept over its five listed mask codes and one unlisted code, and masks with bits 10 and 11 set show that those bits leave the size unchanged.

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder #(
  parameter int NB     = 4,
  parameter int PA_W   = 43,
  parameter int UP_LSB = 26,
  parameter int UP_FW  = 17,
  parameter int UP_W   = 12,
  parameter int LO_LSB = 6,
  parameter int LO_W   = 4,
  parameter int PORT_W = 5,
  localparam int IDX_W = $clog2(NB),
  localparam int GID_W = PORT_W + IDX_W,
  localparam int CFG_W = 1 + 2*UP_W + 2*LO_W,
  localparam int ILV_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_bank,
  input  logic [CFG_W-1:0]    cfg_data,
  input  logic [PORT_W-1:0]   port_id,
  input  logic                lookup_valid,
  input  logic [PA_W-1:0]     lookup_addr,
  output logic                hit,
  output logic [IDX_W-1:0]    hit_bank,
  output logic [GID_W-1:0]    hit_gid,
  output logic [NB*PA_W-1:0]  bank_base,
  output logic [NB*ILV_W-1:0] bank_ilv,
  output logic [NB*PA_W-1:0]  bank_size
);

  logic [NB-1:0]   vld;
  logic [UP_W-1:0] uk [NB];
  logic [UP_W-1:0] um [NB];
  logic [LO_W-1:0] lk [NB];
  logic [LO_W-1:0] lm [NB];
  logic [NB-1:0]   match;

  wire [UP_FW-1:0] ufld = lookup_addr[UP_LSB +: UP_FW];
  wire [LO_W-1:0]  lfld = lookup_addr[LO_LSB +: LO_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < NB; i++) begin
        uk[i] <= '0;
        um[i] <= '0;
        lk[i] <= '0;
        lm[i] <= '0;
      end
    end else if (cfg_we) begin
      lm[cfg_bank]  <= cfg_data[0 +: LO_W];
      lk[cfg_bank]  <= cfg_data[LO_W +: LO_W];
      um[cfg_bank]  <= cfg_data[2*LO_W +: UP_W];
      uk[cfg_bank]  <= cfg_data[2*LO_W+UP_W +: UP_W];
      vld[cfg_bank] <= cfg_data[CFG_W-1];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [2:0]      sh;
    logic [PA_W-1:0] units;

    assign match[b] = vld[b]
      && (((ufld ^ UP_FW'(um[b])) & ~UP_FW'(uk[b])) == '0)
      && (((lfld ^ lm[b]) & ~lk[b]) == '0);

    always_comb begin
      case (lk[b])
        4'hE:    sh = 3'd1;
        4'hC:    sh = 3'd2;
        4'h8:    sh = 3'd3;
        4'h0:    sh = 3'd4;
        default: sh = 3'd0;
      endcase
    end

    assign units = PA_W'(uk[b][9:0]) + PA_W'(1);
    assign bank_ilv[b*ILV_W +: ILV_W]  = ILV_W'(1) << sh;
    assign bank_base[b*PA_W +: PA_W]   = PA_W'(um[b] & ~uk[b]) << UP_LSB;
    assign bank_size[b*PA_W +: PA_W]   = (units << UP_LSB) >> sh;
  end

  logic             any_m;
  logic [IDX_W-1:0] first_m;

  always_comb begin
    any_m   = 1'b0;
    first_m = '0;
    for (int i = NB-1; i >= 0; i--) begin
      if (match[i]) begin
        any_m   = 1'b1;
        first_m = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      hit_bank <= '0;
      hit_gid  <= '0;
    end else begin
      hit      <= lookup_valid && any_m;
      hit_bank <= (lookup_valid && any_m) ? first_m : '0;
      hit_gid  <= (lookup_valid && any_m) ? GID_W'(port_id) * GID_W'(NB) + GID_W'(first_m) : '0;
    end
  end

endmodule

module mem_bank_decoder_chk #(
  parameter int NB     = 4,
  parameter int PORT_W = 5,
  parameter int IDX_W  = 2,
  parameter int GID_W  = 7,
  parameter int ILV_W  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lookup_valid,
  input logic [PORT_W-1:0]   port_id,
  input logic                hit,
  input logic [IDX_W-1:0]    hit_bank,
  input logic [GID_W-1:0]    hit_gid,
  input logic [NB-1:0]       vld,
  input logic [NB*ILV_W-1:0] bank_ilv
);

  assert_hit_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(lookup_valid));

  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_bank == '0 && hit_gid == '0));

  assert_gid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> hit_gid == GID_W'($past(port_id)) * GID_W'(NB) + GID_W'(hit_bank));

  assert_hit_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((($past(vld) >> hit_bank) & NB'(1)) != '0));

  for (genvar b = 0; b < NB; b++) begin : g_ilv
    assert_ilv_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bank_ilv[b*ILV_W +: ILV_W]) == 1);
  end

endmodule

bind mem_bank_decoder mem_bank_decoder_chk #(
  .NB(NB), .PORT_W(PORT_W), .IDX_W(IDX_W), .GID_W(GID_W), .ILV_W(ILV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .port_id(port_id),
  .hit(hit), .hit_bank(hit_bank), .hit_gid(hit_gid), .vld(vld), .bank_ilv(bank_ilv)
);

// File: tb/mem_bank_decoder_bench.sv
module mem_bank_decoder_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_bank = '0;
  logic [32:0]  cfg_data = '0;
  logic [4:0]   port_id = '0;
  logic         lookup_valid = 1'b0;
  logic [42:0]  lookup_addr = '0;
  logic         hit;
  logic [1:0]   hit_bank;
  logic [6:0]   hit_gid;
  logic [171:0] bank_base;
  logic [19:0]  bank_ilv;
  logic [171:0] bank_size;

  always #2 clk = ~clk;

  mem_bank_decoder u_mem_bank_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_data(cfg_data),
    .port_id(port_id), .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .hit(hit), .hit_bank(hit_bank), .hit_gid(hit_gid),
    .bank_base(bank_base), .bank_ilv(bank_ilv), .bank_size(bank_size)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_req = "R10";

  bit     m_v [4];
  longint m_uk [4], m_um [4], m_lk [4], m_lm [4];
  bit     e_hit;
  int     e_idx, e_gid;

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit fld_ok(longint f, longint key, longint msk, int w);
    for (int i = 0; i < w; i++)
      if (((msk >> i) & 1) == 0 && ((f >> i) & 1) != ((key >> i) & 1)) return 0;
    return 1;
  endfunction

  function automatic int ilv_of(longint lk);
    case (lk)
      15: return 1;
      14: return 2;
      12: return 4;
      8:  return 8;
      0:  return 16;
      default: return 1;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    e_hit = 0; e_idx = 0; e_gid = 0;
    if (lookup_valid) begin
      for (int b = 3; b >= 0; b--) begin
        longint up = (longint'(lookup_addr) >> 26) & 'h1FFFF;
        longint lo = (longint'(lookup_addr) >> 6) & 'hF;
        if (m_v[b] && fld_ok(up, m_um[b], m_uk[b], 17) && fld_ok(lo, m_lm[b], m_lk[b], 4)) begin
          e_hit = 1; e_idx = b; e_gid = 4 * int'(port_id) + b;
        end
      end
    end
    if (cfg_we) begin
      m_lm[cfg_bank] = cfg_data[3:0];
      m_lk[cfg_bank] = cfg_data[7:4];
      m_um[cfg_bank] = cfg_data[19:8];
      m_uk[cfg_bank] = cfg_data[31:20];
      m_v[cfg_bank]  = cfg_data[32];
    end
    @(negedge clk);
    chk(cur_req, "hit", hit, e_hit);
    chk(cur_req, "hit_bank", hit_bank, e_idx);
    chk(cur_req, "hit_gid", hit_gid, e_gid);
    for (int b = 0; b < 4; b++) begin
      longint bs = (m_um[b] & ~m_uk[b]) * (longint'(1) << 26);
      longint sz = ((m_uk[b] % 1024) + 1) * (longint'(1) << 26) / ilv_of(m_lk[b]);
      chk("R7", "interleave", bank_ilv[b*5 +: 5], ilv_of(m_lk[b]));
      chk("R8", "base", bank_base[b*43 +: 43], bs);
      chk("R9", "size", bank_size[b*43 +: 43], sz);
    end
  endtask

  task automatic wr(int b, bit v, int uk, int um, int lk, int lm);
    cfg_we = 1; cfg_bank = 2'(b);
    cfg_data = {v, 12'(uk), 12'(um), 4'(lk), 4'(lm)};
    step();
    cfg_we = 0;
  endtask

  task automatic look(longint addr);
    lookup_valid = 1; lookup_addr = 43'(addr);
    step();
    lookup_valid = 0;
    step();
  endtask

  function automatic longint mk(longint up, longint lo);
    return (up << 26) | (lo << 6);
  endfunction

  initial begin
    for (int b = 0; b < 4; b++) begin
      m_v[b] = 0; m_uk[b] = 0; m_um[b] = 0; m_lk[b] = 0; m_lm[b] = 0;
    end
    repeat (3) @(negedge clk);
    cur_req = "R10";
    chk("R10", "reset hit", hit, 0);
    chk("R10", "reset ilv", bank_ilv[4:0], 16);
    chk("R10", "reset size", bank_size[42:0], longint'(1) << 22);
    rst_n = 1;
    step();
    look(mk(0, 0));

    cur_req = "R2";
    wr(0, 1, 'h000, 'h005, 'hF, 'h3);
    look(mk('h005, 0));
    look(mk('h004, 0));
    wr(0, 1, 'h00F, 'h005, 'hF, 'h3);
    look(mk('h00A, 7));
    look(mk('h015, 7));

    cur_req = "R3";
    wr(0, 1, 'hFFF, 'h000, 'h0, 'h9);
    look(mk('h123, 9));
    look(mk('h123, 8));
    wr(0, 1, 'hFFF, 'h000, 'h8, 'h1);
    look(mk('h0, 9));
    look(mk('h0, 3));

    cur_req = "R1";
    wr(0, 0, 'hFFF, 'h000, 'hF, 'h0);
    look(mk('h7, 2));

    cur_req = "R4";
    wr(1, 1, 'hFFF, 'h000, 'hF, 'h0);
    wr(3, 1, 'hFFF, 'h000, 'hF, 'h0);
    look(mk('h55, 5));
    wr(1, 0, 'hFFF, 'h000, 'hF, 'h0);
    look(mk('h55, 5));

    cur_req = "R5";
    port_id = 5'h13;
    look(mk('h1, 1));
    port_id = 5'h1F;
    wr(2, 1, 'h000, 'hABC, 'hF, 'h0);
    look(mk('hABC, 4));

    cur_req = "R11";
    look(mk('h10000 | 'h1, 1));
    look((longint'(1) << 42));

    cur_req = "R6";
    lookup_addr = 43'(mk('hABC, 4));
    step();
    step();

    cur_req = "R7";
    wr(2, 1, 'h3F0, 'h0F5, 'hE, 'h0);
    wr(2, 1, 'h3F0, 'h0F5, 'hC, 'h0);
    wr(2, 1, 'h3F0, 'h0F5, 'h8, 'h0);
    wr(2, 1, 'h3F0, 'h0F5, 'h0, 'h0);
    wr(2, 1, 'h3F0, 'h0F5, 'h5, 'h0);

    cur_req = "R9";
    wr(2, 1, 'hC0F, 'hFFF, 'hE, 'h0);
    wr(0, 1, 'h400, 'h3FF, 'h0, 'h0);
    look(mk('h3FF, 3));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule